// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block performs the byte steering behind the left and right partial-word loads and stores of a little-endian 32-bit core. On the load side it takes the low address bits, the aligned memory word that holds the addressed byte, and the latest value of the destination register. That register value must already include any load still in flight to it. The block returns the merged register value, which the core then writes back through its normal delayed-load path.

On the store side it takes the low address bits and the source register. It returns a lane write mask and lane-aligned write data for a single aligned word access. Unaligned addresses never raise an error here; every offset yields a result.

The load path and the store path are independent. Each has its own issue strobe and can be issued in the same cycle as the other. Both results pass through one output register stage, so every result appears one clock after issue. The address adder and the memory system sit outside the block.

Top module: `uwm_unit`

## Requirements
- R1: Left load (direction 0) with offset o (address bits 1:0): memory lanes 0..o fill result lanes 3-o..3, keeping their order. The byte at the addressed lane lands in bits 31:24. Lane k holds bits 8k+7:8k.
- R2: Left load: result lanes 0..2-o keep the old register value.
- R3: Right load (direction 1): memory lanes o..3 fill result lanes 0..3-o. The addressed byte lands in bits 7:0.
- R4: Right load: result lanes 4-o..3 keep the old register value.
- R5: Left store (direction 0): the mask enables lanes 0..o. Lane k carries source byte 3-o+k. Disabled lanes carry zero.
- R6: Right store (direction 1): the mask enables lanes o..3. Lane k carries source byte k-o. Disabled lanes carry zero.
- R7: A result and its valid flag appear on the outputs at the first rising edge after issue. This holds for every offset, with no error indication.
- R8: While reset (active low) is held, both valid flags, the mask, the store data and the load result are zero.
- R9: A cycle with no store issued gives st_valid low, a zero mask and zero store data on the next edge.
- R10: A load and a store issued in the same cycle each produce their own correct result in the same output cycle.
- R11: A cycle with no load issued leaves ld_result holding its previous value, with ld_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_issue | input | 1 | Partial load request this cycle |
| ld_dir | input | 1 | 0 = left load, 1 = right load |
| ld_off | input | 2 | Low address bits of the load |
| ld_mem | input | 32 | Aligned memory word containing the addressed byte |
| ld_old | input | 32 | Latest destination register value, in-flight load included |
| st_issue | input | 1 | Partial store request this cycle |
| st_dir | input | 1 | 0 = left store, 1 = right store |
| st_off | input | 2 | Low address bits of the store |
| st_src | input | 32 | Source register value |
| ld_valid | output | 1 | Merged load result valid |
| ld_result | output | 32 | Merged register value |
| st_valid | output | 1 | Store lane data valid |
| st_be | output | 4 | Lane write mask |
| st_data | output | 32 | Lane-aligned store data |

## Verification
The load merge and the store alignment can both complete in the same output cycle. The table walk provokes this on every row by issuing a load and a store together, each with a different offset and direction. Each row pairs a left load with a right store, or the reverse, so that a crossed shift or a shared offset would corrupt one side. Both results are judged against hand-derived values in the cycle after issue. Directed steps then issue each side alone to confirm the other side idles or holds.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
   typedef enum logic {
      DIR_LEFT  = 1'b0,
      DIR_RIGHT = 1'b1
   } uwm_dir_e;
endpackage

// File: rtl/uwm_load_merge.sv
module uwm_load_merge
   import uwm_pkg::*;
#(
   parameter  int DATA_W = 32,
   parameter  int LANE_W = 8,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic              dir,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] mem_word,
   input  logic [DATA_W-1:0] old_word,
   output logic [DATA_W-1:0] merged
);
   // Each result lane picks either a memory lane or its own old lane.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      int               pos;
      logic             take;
      logic [OFF_W-1:0] sel;
      logic [LANE_W-1:0] lane_out;

      always_comb begin
         pos = i + int'(off);
         if (dir == DIR_LEFT) begin
            take = (pos >= LANES - 1);
            sel  = OFF_W'(pos - (LANES - 1));
         end else begin
            take = (pos <= LANES - 1);
            sel  = OFF_W'(pos);
         end
         lane_out = take ? mem_word[sel*LANE_W +: LANE_W]
                         : old_word[i*LANE_W +: LANE_W];
      end

      assign merged[i*LANE_W +: LANE_W] = lane_out;
   end
endmodule

// File: rtl/uwm_store_align.sv
module uwm_store_align
   import uwm_pkg::*;
#(
   parameter  int DATA_W = 32,
   parameter  int LANE_W = 8,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic              dir,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] src_word,
   output logic [LANES-1:0]  lane_en,
   output logic [DATA_W-1:0] lane_data
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      int                pos;
      logic              en;
      logic [OFF_W-1:0]  sel;
      logic [LANE_W-1:0] lane_out;

      always_comb begin
         if (dir == DIR_LEFT) begin
            en  = (k <= int'(off));
            pos = k + (LANES - 1) - int'(off);
         end else begin
            en  = (k >= int'(off));
            pos = k - int'(off);
         end
         sel      = OFF_W'(pos);
         lane_out = en ? src_word[sel*LANE_W +: LANE_W] : '0;
      end

      assign lane_en[k]                    = en;
      assign lane_data[k*LANE_W +: LANE_W] = lane_out;
   end
endmodule

// File: rtl/uwm_pipe_reg.sv
module uwm_pipe_reg #(
   parameter int W          = 32,
   parameter bit CLEAR_IDLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   if (CLEAR_IDLE) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n)        out_data <= '0;
         else if (in_valid) out_data <= in_data;
         else               out_data <= '0;
      end
   end else begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)        out_data <= '0;
         else if (in_valid) out_data <= in_data;
      end
   end
endmodule

// File: rtl/uwm_unit.sv
module uwm_unit
   import uwm_pkg::*;
#(
   parameter  int DATA_W = 32,
   parameter  int LANE_W = 8,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_issue,
   input  logic              ld_dir,
   input  logic [OFF_W-1:0]  ld_off,
   input  logic [DATA_W-1:0] ld_mem,
   input  logic [DATA_W-1:0] ld_old,
   input  logic              st_issue,
   input  logic              st_dir,
   input  logic [OFF_W-1:0]  st_off,
   input  logic [DATA_W-1:0] st_src,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_result,
   output logic              st_valid,
   output logic [LANES-1:0]  st_be,
   output logic [DATA_W-1:0] st_data
);
   localparam int ST_W = LANES + DATA_W;

   if (LANE_W < 1 || (DATA_W % LANE_W) != 0 || LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_cfg
      $error("uwm_unit: DATA_W must split into a power-of-two count (>=2) of LANE_W lanes");
   end

   logic [DATA_W-1:0] merged_d;
   logic [LANES-1:0]  en_d;
   logic [DATA_W-1:0] sdata_d;
   logic [ST_W-1:0]   st_q;

   uwm_load_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load (
      .dir(ld_dir), .off(ld_off), .mem_word(ld_mem), .old_word(ld_old), .merged(merged_d)
   );

   uwm_store_align #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_store (
      .dir(st_dir), .off(st_off), .src_word(st_src), .lane_en(en_d), .lane_data(sdata_d)
   );

   uwm_pipe_reg #(.W(DATA_W), .CLEAR_IDLE(1'b0)) u_ld_reg (
      .clk(clk), .rst_n(rst_n), .in_valid(ld_issue), .in_data(merged_d),
      .out_valid(ld_valid), .out_data(ld_result)
   );

   uwm_pipe_reg #(.W(ST_W), .CLEAR_IDLE(1'b1)) u_st_reg (
      .clk(clk), .rst_n(rst_n), .in_valid(st_issue), .in_data({en_d, sdata_d}),
      .out_valid(st_valid), .out_data(st_q)
   );

   assign st_be   = st_q[ST_W-1 -: LANES];
   assign st_data = st_q[DATA_W-1:0];

   // R1: addressed byte ends in the top lane on a left load
   assert_ll_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_issue && ld_dir == DIR_LEFT) |=>
      ld_result[DATA_W-1 -: LANE_W] == $past(ld_mem[ld_off*LANE_W +: LANE_W]));

   // R2: lane 0 survives a left load unless the offset is the last lane
   assert_ll_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_issue && ld_dir == DIR_LEFT && ld_off != OFF_W'(LANES-1)) |=>
      ld_result[LANE_W-1:0] == $past(ld_old[LANE_W-1:0]));

   // R3: addressed byte ends in lane 0 on a right load
   assert_lr_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_issue && ld_dir == DIR_RIGHT) |=>
      ld_result[LANE_W-1:0] == $past(ld_mem[ld_off*LANE_W +: LANE_W]));

   // R4: top lane survives a right load with nonzero offset
   assert_lr_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_issue && ld_dir == DIR_RIGHT && ld_off != '0) |=>
      ld_result[DATA_W-1 -: LANE_W] == $past(ld_old[DATA_W-1 -: LANE_W]));

   // R5: left store enables offset+1 lanes starting at lane 0
   assert_sl_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_issue && st_dir == DIR_LEFT) |=>
      (st_be[0] && $countones(st_be) == int'($past(st_off)) + 1));

   // R6: right store enables lanes from the offset to the top lane
   assert_sr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_issue && st_dir == DIR_RIGHT) |=>
      (st_be[LANES-1] && $countones(st_be) == LANES - int'($past(st_off))));

   // R7: valid flags follow issue by one clock
   assert_ld_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_issue |=> ld_valid);
   assert_st_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      st_issue |=> st_valid);

   // R9: an idle store slot writes nothing
   assert_st_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !st_issue |=> (!st_valid && st_be == '0 && st_data == '0));

   // R11: an idle load slot holds the last result
   assert_ld_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_issue |=> (!ld_valid && $stable(ld_result)));
endmodule

// File: tb/sim_uwm_unit.sv
`timescale 1ns/1ps
module sim_uwm_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_issue = 1'b0, ld_dir = 1'b0;
   logic [1:0]  ld_off = '0;
   logic [31:0] ld_mem = '0, ld_old = '0;
   logic        st_issue = 1'b0, st_dir = 1'b0;
   logic [1:0]  st_off = '0;
   logic [31:0] st_src = '0;
   logic        ld_valid, st_valid;
   logic [31:0] ld_result, st_data;
   logic [3:0]  st_be;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uwm_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .ld_issue(ld_issue), .ld_dir(ld_dir), .ld_off(ld_off), .ld_mem(ld_mem), .ld_old(ld_old),
      .st_issue(st_issue), .st_dir(st_dir), .st_off(st_off), .st_src(st_src),
      .ld_valid(ld_valid), .ld_result(ld_result),
      .st_valid(st_valid), .st_be(st_be), .st_data(st_data)
   );

   // row: ld_dir, ld_off, expected load, st_dir, st_off, expected mask, expected store data
   // fixed operands: mem 44332211, old AABBCCDD, src A1B2C3D4
   localparam logic [73:0] TBL [8] = '{
      {1'b0, 2'd0, 32'h11BBCCDD, 1'b1, 2'd3, 4'b1000, 32'hD4000000},
      {1'b0, 2'd1, 32'h2211CCDD, 1'b1, 2'd2, 4'b1100, 32'hC3D40000},
      {1'b0, 2'd2, 32'h332211DD, 1'b1, 2'd1, 4'b1110, 32'hB2C3D400},
      {1'b0, 2'd3, 32'h44332211, 1'b1, 2'd0, 4'b1111, 32'hA1B2C3D4},
      {1'b1, 2'd0, 32'h44332211, 1'b0, 2'd3, 4'b1111, 32'hA1B2C3D4},
      {1'b1, 2'd1, 32'hAA443322, 1'b0, 2'd2, 4'b0111, 32'h00A1B2C3},
      {1'b1, 2'd2, 32'hAABB4433, 1'b0, 2'd1, 4'b0011, 32'h0000A1B2},
      {1'b1, 2'd3, 32'hAABBCC44, 1'b0, 2'd0, 4'b0001, 32'h000000A1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 ld_valid", {31'd0, ld_valid}, 0);
      chk("R8 st_valid", {31'd0, st_valid}, 0);
      chk("R8 st_be", {28'd0, st_be}, 0);
      chk("R8 st_data", st_data, 0);
      chk("R8 ld_result", ld_result, 0);
      rst_n = 1'b1;
      tick();

      // table walk: load and store together every row (R10)
      ld_mem = 32'h44332211; ld_old = 32'hAABBCCDD; st_src = 32'hA1B2C3D4;
      for (int r = 0; r < 8; r++) begin
         ld_issue = 1'b1; st_issue = 1'b1;
         ld_dir = TBL[r][73]; ld_off = TBL[r][72:71];
         st_dir = TBL[r][38]; st_off = TBL[r][37:36];
         tick();
         chk(ld_dir ? "R3 R4 R10 load right" : "R1 R2 R10 load left", ld_result, TBL[r][70:39]);
         chk(st_dir ? "R6 R10 store right mask" : "R5 R10 store left mask", {28'd0, st_be}, {28'd0, TBL[r][35:32]});
         chk(st_dir ? "R6 R10 store right data" : "R5 R10 store left data", st_data, TBL[r][31:0]);
         chk("R7 valids", {30'd0, ld_valid, st_valid}, 32'd3);
      end

      // load alone, second pattern; R7 latency checked before and after edge
      ld_issue = 1'b1; st_issue = 1'b0;
      ld_dir = 1'b0; ld_off = 2'd1; ld_mem = 32'hFFEEDDCC; ld_old = 32'h01234567;
      #1;
      chk("R7 no change before edge", ld_result, 32'hAABBCC44);
      tick();
      chk("R1 R2 left load pattern2", ld_result, 32'hDDCC4567);
      chk("R9 store idle valid", {31'd0, st_valid}, 0);
      chk("R9 store idle mask", {28'd0, st_be}, 0);
      chk("R9 store idle data", st_data, 0);

      // store alone; load output must hold
      ld_issue = 1'b0; st_issue = 1'b1;
      st_dir = 1'b1; st_off = 2'd2; st_src = 32'h11223344;
      ld_mem = 32'h0; ld_old = 32'h0;
      tick();
      chk("R6 right store pattern2 mask", {28'd0, st_be}, 32'hC);
      chk("R6 right store pattern2 data", st_data, 32'h33440000);
      chk("R11 load idle valid", {31'd0, ld_valid}, 0);
      chk("R11 load idle holds", ld_result, 32'hDDCC4567);

      // right load at last offset
      ld_issue = 1'b1; st_issue = 1'b0;
      ld_dir = 1'b1; ld_off = 2'd3; ld_mem = 32'hFFEEDDCC; ld_old = 32'h01234567;
      tick();
      chk("R3 R4 right load pattern2", ld_result, 32'h012345FF);
      ld_issue = 1'b0;
      tick();
      chk("R7 ld_valid drops", {31'd0, ld_valid}, 0);

      // reset mid-run
      ld_issue = 1'b1; st_issue = 1'b1;
      tick();
      rst_n = 1'b0;
      tick();
      chk("R8 reset ld_result", ld_result, 0);
      chk("R8 reset st_be", {28'd0, st_be}, 0);
      chk("R8 reset valids", {30'd0, ld_valid, st_valid}, 0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule